// File: doc/BRIEF.md
# Shared Single Barrel Shifter

This unit performs the three integer shift operations of a 32-bit scalar ALU (logical left, logical right, arithmetic right) on one 33-bit right-shifting barrel shifter rather than on three separate shifters. An extra top bit on the shifter input carries the fill value. It is the sign of the operand for an arithmetic shift and zero otherwise. A left shift is obtained by reversing the operand's bit order before the shifter and reversing the shifter's output after it.

The execute stage presents the operand `a`, the second operand `b` (only its low five bits form the shift amount) and a one-hot operation select. The result is captured in a register on the rising clock edge. While the pipeline stall input is high, the register keeps its value.

Top module: `shared_shift_unit`

## Requirements
- R1: While `rst_n` is low, `result` is 0 at every rising clock edge.
- R2: With `op_sel` = 3'b001 (logical left), `result` becomes `a` shifted left by the amount, with zeros entering from bit 0.
- R3: With `op_sel` = 3'b010 (logical right), `result` becomes `a` shifted right by the amount, with zeros entering from bit 31.
- R4: With `op_sel` = 3'b100 (arithmetic right), `result` becomes `a` shifted right by the amount, with copies of `a[31]` entering from bit 31.
- R5: The shift amount is `b[4:0]`. Bits 31:5 of `b` have no effect on `result`.
- R6: An amount of 0 returns `a` unchanged for all three operations. An amount of 31 leaves only one original bit (bit 31 for left shifts, bit 0 for right shifts), or the sign fill for arithmetic right shifts.
- R7: `result` reflects the inputs present at a rising edge where `stall` is low, from that edge until the next loading edge. The latency is one cycle.
- R8: At a rising edge where `stall` is high, `result` keeps its previous value, whatever operation and operands are presented.
- R9: Any `op_sel` value other than 3'b001, 3'b010 or 3'b100 (zero or more than one bit set) loads 0 into `result`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| stall | input | 1 | Hold the result register when high |
| op_sel | input | 3 | One-hot operation: bit 0 left logical, bit 1 right logical, bit 2 right arithmetic |
| a | input | 32 | Operand to be shifted |
| b | input | 32 | Second operand; bits 4:0 give the shift amount |
| result | output | 32 | Registered shift result |

## Verification
Two functions can fall in the same cycle: a new shift request can arrive in the same cycle as a stall. In that cycle the hold must win, and the request must not leak into the register. The bench provokes this by presenting fresh operands and every operation code while `stall` is high, including runs of consecutive stalled cycles. It judges the outcome by checking that `result` equals the last value loaded before the stall. It then checks that the first unstalled request after the stall loads correctly, one cycle later.

// File: rtl/shift_unit_pkg.sv
// Package: shared constants for the shift unit.
// Assumes a one-hot operation select of three bits.
package shift_unit_pkg;
    localparam int OP_W = 3;
    localparam logic [OP_W-1:0] OP_SLL = 3'b001;
    localparam logic [OP_W-1:0] OP_SRL = 3'b010;
    localparam logic [OP_W-1:0] OP_SRA = 3'b100;
endpackage

// File: rtl/shift_operand_prep.sv
// Builds the extended shifter input: the reversed operand for left shifts,
// or the operand with a fill bit on top for right shifts.
// Assumes op_left and op_arith are never high together.
module shift_operand_prep #(
    parameter int DATA_W = 32,
    localparam int EXT_W = DATA_W + 1
) (
    input  logic [DATA_W-1:0] a,
    input  logic              op_left,
    input  logic              op_arith,
    output logic [EXT_W-1:0]  ext
);
    logic [DATA_W-1:0] a_rev;

    // Mirror the operand's bit order.
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign a_rev[i] = a[DATA_W-1-i];
    end

    // Choose the shifter input and its fill bit.
    always_comb begin
        if (op_left)
            ext = {1'b0, a_rev};
        else
            ext = {op_arith & a[DATA_W-1], a};
    end
endmodule

// File: rtl/shift_right_core.sv
// Logarithmic right barrel shifter. Each stage shifts by a power of two
// and fills from the input's top bit, so the top bit sets the fill.
// Assumes amt never exceeds EXT_W-1.
module shift_right_core #(
    parameter int EXT_W = 33,
    parameter int AMT_W = 5
) (
    input  logic [EXT_W-1:0] din,
    input  logic [AMT_W-1:0] amt,
    output logic [EXT_W-1:0] dout
);
    logic [EXT_W-1:0] lvl [0:AMT_W];
    logic             fill;

    assign fill   = din[EXT_W-1];
    assign lvl[0] = din;

    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        localparam int STEP = 1 << s;
        // Stage s: shift by STEP when amount bit s is set.
        always_comb begin
            if (amt[s])
                lvl[s+1] = {{STEP{fill}}, lvl[s][EXT_W-1:STEP]};
            else
                lvl[s+1] = lvl[s];
        end
    end

    assign dout = lvl[AMT_W];
endmodule

// File: rtl/shift_result_finish.sv
// Drops the extension bit, re-reverses for left shifts, and forces zero
// for an invalid operation select.
module shift_result_finish #(
    parameter int DATA_W = 32,
    localparam int EXT_W = DATA_W + 1
) (
    input  logic [EXT_W-1:0]  sh_out,
    input  logic              op_left,
    input  logic              op_valid,
    output logic [DATA_W-1:0] res
);
    logic [DATA_W-1:0] low;
    logic [DATA_W-1:0] low_rev;
    logic              unused_ext;

    assign low        = sh_out[DATA_W-1:0];
    assign unused_ext = sh_out[EXT_W-1];

    // Undo the bit reversal applied before a left shift.
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign low_rev[i] = low[DATA_W-1-i];
    end

    // Pick the final orientation or zero.
    always_comb begin
        if (!op_valid)
            res = '0;
        else if (op_left)
            res = low_rev;
        else
            res = low;
    end
endmodule

// File: rtl/shared_shift_unit.sv
// Shift unit for the three integer shifts on one shared right shifter.
// The result is registered. It holds under stall and clears on synchronous reset.
// Assumes b[SHAMT_W-1:0] is the shift amount; the upper bits of b are ignored.
module shared_shift_unit
    import shift_unit_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SHAMT_W = $clog2(DATA_W),
    localparam int EXT_W = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic [OP_W-1:0]   op_sel,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] result
);
    logic               is_sll, is_srl, is_sra, op_valid;
    logic [EXT_W-1:0]   sh_in, sh_out;
    logic [DATA_W-1:0]  next_res;
    logic [SHAMT_W-1:0] shamt;
    logic               unused_b;

    // Decode the operation select; only the exact one-hot codes are valid.
    always_comb begin
        is_sll   = (op_sel == OP_SLL);
        is_srl   = (op_sel == OP_SRL);
        is_sra   = (op_sel == OP_SRA);
        op_valid = is_sll | is_srl | is_sra;
    end

    assign shamt    = b[SHAMT_W-1:0];
    assign unused_b = ^b[DATA_W-1:SHAMT_W];

    shift_operand_prep #(.DATA_W(DATA_W)) prep_i (
        .a        (a),
        .op_left  (is_sll),
        .op_arith (is_sra),
        .ext      (sh_in)
    );

    shift_right_core #(.EXT_W(EXT_W), .AMT_W(SHAMT_W)) core_i (
        .din  (sh_in),
        .amt  (shamt),
        .dout (sh_out)
    );

    shift_result_finish #(.DATA_W(DATA_W)) fin_i (
        .sh_out   (sh_out),
        .op_left  (is_sll),
        .op_valid (op_valid),
        .res      (next_res)
    );

    // Result register: clear on reset, hold on stall, else load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            result <= '0;
        else if (!stall)
            result <= next_res;
    end
endmodule

// File: rtl/shared_shift_unit_chk.sv
// Checker for the shift unit, compared against the native shift operators.
module shared_shift_unit_chk #(
    parameter int DATA_W = 32,
    localparam int SHAMT_W = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stall,
    input logic [2:0]        op_sel,
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b,
    input logic [DATA_W-1:0] result
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> result == '0);

    // R2
    sll_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && op_sel == 3'b001) |=>
        result == ($past(a) << $past(b[SHAMT_W-1:0])));

    // R3
    srl_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && op_sel == 3'b010) |=>
        result == ($past(a) >> $past(b[SHAMT_W-1:0])));

    // R4
    sra_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && op_sel == 3'b100) |=>
        result == DATA_W'($signed($past(a)) >>> $past(b[SHAMT_W-1:0])));

    // R6
    zero_amount_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && $countones(op_sel) == 1 && b[SHAMT_W-1:0] == '0) |=>
        result == $past(a));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(result));

    // R9
    bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && $countones(op_sel) != 1) |=> result == '0);
endmodule

bind shared_shift_unit shared_shift_unit_chk #(.DATA_W(DATA_W)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .stall  (stall),
    .op_sel (op_sel),
    .a      (a),
    .b      (b),
    .result (result)
);

// File: tb/shared_shift_unit_tb_top.sv
// Scoreboard bench: the driver queues expected results; the monitor compares them.
module shared_shift_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall = 1'b0;
    logic [2:0]  op_sel = 3'b000;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [31:0] result;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    int          total = 0;
    int          bad = 0;
    logic [31:0] last_exp = '0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    shared_shift_unit dut_i (
        .clk(clk), .rst_n(rst_n), .stall(stall), .op_sel(op_sel),
        .a(a), .b(b), .result(result)
    );

    function automatic logic [31:0] model(input logic [2:0] op,
                                          input logic [31:0] x,
                                          input logic [31:0] y);
        logic [4:0] sh;
        sh = y[4:0];
        case (op)
            3'b001:  return x << sh;
            3'b010:  return x >> sh;
            3'b100:  return 32'($signed(x) >>> sh);
            default: return 32'h0;
        endcase
    endfunction

    // Driver: present one request and queue its expected result.
    task automatic issue(input logic [2:0] op, input logic [31:0] x,
                         input logic [31:0] y, input bit st, input string tag);
        item_t it;
        @(negedge clk);
        op_sel = op; a = x; b = y; stall = st;
        if (!st) last_exp = model(op, x, y);
        it.exp = last_exp;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: after each edge, compare the result with the oldest expectation.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            total++;
            if (result !== it.exp) begin
                bad++;
                $display("FAIL %s: result=%h expected=%h", it.tag, result, it.exp);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(5 * 100000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: result=%h expected=completion", result);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: result cleared during reset, even with a valid request present
        @(negedge clk);
        op_sel = 3'b001; a = 32'hFFFF_FFFF; b = 32'd1;
        repeat (3) @(negedge clk);
        total++;
        if (result !== 32'h0) begin
            bad++;
            $display("FAIL R1: result=%h expected=%h", result, 32'h0);
        end
        rst_n = 1'b1;

        // R6: amount zero and amount 31 on each operation
        issue(3'b001, 32'h8000_0001, 32'd0,  1'b0, "R6 sll 0");
        issue(3'b010, 32'h8000_0001, 32'd0,  1'b0, "R6 srl 0");
        issue(3'b100, 32'h8000_0001, 32'd0,  1'b0, "R6 sra 0");
        issue(3'b001, 32'h8000_0001, 32'd31, 1'b0, "R6 sll 31");
        issue(3'b010, 32'h8000_0001, 32'd31, 1'b0, "R6 srl 31");
        issue(3'b100, 32'h8000_0001, 32'd31, 1'b0, "R6 sra 31");
        issue(3'b100, 32'h7FFF_FFFF, 32'd31, 1'b0, "R6 sra 31 pos");

        // R2 R3 R4 R7: random operands on every operation, back to back
        for (int i = 0; i < 60; i++) begin
            logic [31:0] x, y;
            x = $urandom; y = $urandom;
            issue(3'b001, x, y, 1'b0, "R2 sll");
            issue(3'b010, x, y, 1'b0, "R3 srl");
            issue(3'b100, x, y, 1'b0, "R4 sra");
        end

        // R5: upper bits of b set; the amount is taken from b[4:0] only
        issue(3'b010, 32'hF000_0000, 32'hFFFF_FFE4, 1'b0, "R5 srl upper");
        issue(3'b001, 32'h0000_000F, 32'h8000_0020, 1'b0, "R5 sll upper");
        issue(3'b100, 32'h8000_0000, 32'h0000_0FE0, 1'b0, "R5 sra upper");

        // R8: stall while fresh requests arrive; hold the last value
        issue(3'b001, 32'h1234_5678, 32'd4,  1'b0, "R7 load before stall");
        issue(3'b100, 32'hDEAD_BEEF, 32'd7,  1'b1, "R8 stall sra");
        issue(3'b010, 32'hCAFE_F00D, 32'd1,  1'b1, "R8 stall srl");
        issue(3'b000, 32'h0,         32'd0,  1'b1, "R8 stall bad op");
        issue(3'b010, 32'hCAFE_F00D, 32'd12, 1'b0, "R7 load after stall");

        // R9: zero and multi-bit selects load 0
        issue(3'b000, 32'hFFFF_FFFF, 32'd3, 1'b0, "R9 op zero");
        issue(3'b011, 32'hFFFF_FFFF, 32'd3, 1'b0, "R9 op 011");
        issue(3'b111, 32'hFFFF_FFFF, 32'd3, 1'b0, "R9 op 111");
        issue(3'b100, 32'hFFFF_FFFF, 32'd3, 1'b0, "R4 after invalid");

        @(negedge clk);
        stall = 1'b1;
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule